// File: doc/BRIEF.md
# Four-Bit XNOR-Feedback Pseudo-Random Sequencer

This block is a four-stage linear feedback shift register that produces a new pseudo-random nibble on every clock in which its enable is high. On each enabled step the stages move up by one place: bit 1 takes bit 0, bit 2 takes bit 1 and bit 3 takes bit 2. Bit 0 takes the XNOR of the two upper stages. The output word has bit 3 as its MSB and bit 0 as its LSB.

Because the feedback uses XNOR, the all-zero word is a normal member of the sequence, and the reset loads that word. The all-ones word is the only state from which the register cannot leave, and the sequence from reset never reaches it. Starting from zero, the register visits the other fifteen values once each and then returns to zero. A one-cycle flag marks every return to zero, so a consumer can count periods or align frames to the sequence.

Top module: `lfsr_xn_top`

## Requirements
- R1: A synchronous active-high reset loads the output 4'b0000 and drives the wrap flag low on the next clock edge.
- R2: On an enabled clock edge the new output is {old[2], old[1], old[0], ~(old[3] ^ old[2])}. Bit 3 is the MSB and bit 0 is the LSB.
- R3: On a clock edge with the enable low, the output keeps its value and the wrap flag is low after that edge.
- R4: Starting from 4'b0000, exactly 15 enabled steps return the output to 4'b0000, and every value other than 4'b1111 appears exactly once in each period.
- R5: The output never takes the value 4'b1111.
- R6: The wrap flag is high for exactly the one cycle that follows an enabled step which loads 4'b0000. It is low in every other cycle.
- R7: Reset takes precedence over the enable. With both high, the output becomes 4'b0000 and the wrap flag stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Advance enable |
| rnd_o | output | 4 | Current pseudo-random word, bit 3 is the MSB |
| wrap_o | output | 1 | One-cycle pulse after a step that returns to zero |

## Verification
Two events can fall on the same edge: the step that wraps to zero, which raises the flag, and a reset or a drop of the enable. The bench provokes both cases. In one, it asserts reset while the enable is high on exactly the wrapping edge, and it expects zero with the flag low. In the other, it lets the wrap step through and then drops the enable on the next edge, and it expects the flag to fall after one cycle while the output holds at zero.

// File: rtl/lfsr_xn_pkg.sv
package lfsr_xn_pkg;

    localparam int unsigned LFSR_W   = 4;
    localparam int unsigned TAP_HI   = 3;
    localparam int unsigned TAP_LO   = 2;
    localparam int unsigned PERIOD   = (1 << LFSR_W) - 1;

    typedef logic [LFSR_W-1:0] lfsr_word_t;

    localparam lfsr_word_t SEED_WORD = '0;
    localparam lfsr_word_t LOCK_WORD = '1;

    typedef struct packed {
        lfsr_word_t word;
        logic       wrap;
    } lfsr_out_t;

    function automatic logic xnor_tap(input lfsr_word_t w);
        return ~(w[TAP_HI] ^ w[TAP_LO]);
    endfunction

endpackage

// File: rtl/lfsr_xn_feedback.sv
module lfsr_xn_feedback
    import lfsr_xn_pkg::*;
(
    input  lfsr_word_t cur_i,
    output logic       fb_o
);
    always_comb begin
        fb_o = xnor_tap(cur_i);
    end
endmodule

// File: rtl/lfsr_xn_shift.sv
module lfsr_xn_shift
    import lfsr_xn_pkg::*;
#(
    parameter int unsigned   WIDTH = LFSR_W,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             fb_i,
    output logic [WIDTH-1:0] q_o,
    output logic [WIDTH-1:0] nxt_o
);
    logic [WIDTH-1:0] d;

    assign d[0] = fb_i;

    for (genvar s = 1; s < WIDTH; s++) begin : g_link
        assign d[s] = q_o[s-1];
    end

    for (genvar s = 0; s < WIDTH; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                q_o[s] <= INIT[s];
            end else if (en_i) begin
                q_o[s] <= d[s];
            end
        end
    end

    assign nxt_o = d;
endmodule

// File: rtl/lfsr_xn_wrap.sv
module lfsr_xn_wrap
    import lfsr_xn_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  lfsr_word_t nxt_i,
    output logic       wrap_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wrap_o <= 1'b0;
        end else begin
            wrap_o <= en_i && (nxt_i == SEED_WORD);
        end
    end
endmodule

// File: rtl/lfsr_xn_top.sv
module lfsr_xn_top
    import lfsr_xn_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        en_i,
    output logic [3:0]  rnd_o,
    output logic        wrap_o
);
    lfsr_word_t cur;
    lfsr_word_t nxt;
    logic       fb;
    lfsr_out_t  outs;

    lfsr_xn_feedback u_fb (
        .cur_i (cur),
        .fb_o  (fb)
    );

    lfsr_xn_shift #(
        .WIDTH (LFSR_W),
        .INIT  (SEED_WORD)
    ) u_shift (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (en_i),
        .fb_i  (fb),
        .q_o   (cur),
        .nxt_o (nxt)
    );

    lfsr_xn_wrap u_wrap (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .nxt_i  (nxt),
        .wrap_o (outs.wrap)
    );

    assign outs.word = cur;
    assign rnd_o     = outs.word;
    assign wrap_o    = outs.wrap;
endmodule

// File: rtl/lfsr_xn_chk.sv
module lfsr_xn_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       en_i,
    input logic [3:0] rnd_o,
    input logic       wrap_o
);
    // R1 and R7: reset wins and clears the word and the flag
    assert_reset_load_R1: assert property (@(posedge clk_i)
        rst_i |=> (rnd_o == 4'b0000) && !wrap_o);

    assert_step_shape_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> rnd_o == {$past(rnd_o[2:0]), ~($past(rnd_o[3]) ^ $past(rnd_o[2]))});

    assert_hold_idle_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(rnd_o) && !wrap_o);

    assert_no_lockup_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        rnd_o != 4'b1111);

    assert_wrap_at_zero_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |-> rnd_o == 4'b0000);

    assert_wrap_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |=> !wrap_o);
endmodule

bind lfsr_xn_top lfsr_xn_chk u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .rnd_o  (rnd_o),
    .wrap_o (wrap_o)
);

// File: tb/tb_lfsr_xn_top.sv
module tb_lfsr_xn_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [3:0] rnd;
    logic       wrap;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    logic [3:0]  mdl = 4'b0000;

    always #5 clk = ~clk;

    lfsr_xn_top dut (
        .clk_i  (clk),
        .rst_i  (rst),
        .en_i   (en),
        .rnd_o  (rnd),
        .wrap_o (wrap)
    );

    function automatic logic [3:0] nx(input logic [3:0] w);
        return {w[2:0], ~(w[3] ^ w[2])};
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive at negedge, sample 1 ns after the next posedge
    task automatic cyc(input logic r, input logic e, input string req);
        logic expw;
        @(negedge clk);
        rst = r;
        en  = e;
        @(posedge clk);
        #1;
        if (r) begin
            mdl  = 4'b0000;
            expw = 1'b0;
        end else if (e) begin
            mdl  = nx(mdl);
            expw = (mdl == 4'b0000);
        end else begin
            expw = 1'b0;
        end
        chk(req, rnd, mdl);
        chk(req, {3'b000, wrap}, {3'b000, expw});
        if (rnd == 4'b1111) chk("R5 lockup seen", rnd, 4'b0000);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seen [16];
        int steps;
        void'($urandom(32'd4321));

        cyc(1'b1, 1'b0, "R1 reset");
        cyc(1'b1, 1'b1, "R7 reset over enable");
        chk("R1 reset word", rnd, 4'b0000);

        // R4: one full period from zero, every non-1111 value once
        for (int i = 0; i < 16; i++) seen[i] = 0;
        seen[0] = 1;
        for (int i = 0; i < 15; i++) begin
            cyc(1'b0, 1'b1, "R2 R6 directed step");
            if (i < 14) seen[rnd]++;
        end
        chk("R4 back to zero after 15", rnd, 4'b0000);
        chk("R6 wrap after 15th step", {3'b000, wrap}, 4'b0001);
        for (int i = 0; i < 15; i++)
            chk("R4 value once per period", seen[i][3:0], 4'b0001);
        chk("R5 1111 absent", seen[15][3:0], 4'b0000);

        // R6 with R3: enable drops right after the wrap step
        cyc(1'b0, 1'b0, "R3 R6 hold after wrap");
        cyc(1'b0, 1'b0, "R3 hold");

        // R7: reset on the wrapping edge
        for (int i = 0; i < 14; i++) cyc(1'b0, 1'b1, "R2 step");
        cyc(1'b1, 1'b1, "R7 reset on wrap edge");

        // random enable: measure period length in enabled steps
        steps = 0;
        for (int i = 0; i < 2000; i++) begin
            logic e;
            e = ($urandom % 3) != 0;
            cyc(1'b0, e, "R2 R3 R6 random");
            if (e) begin
                steps++;
                if (rnd == 4'b0000) begin
                    chk("R4 period length", steps[3:0], 4'd15);
                    steps = 0;
                end
            end
        end

        cyc(1'b1, 1'b0, "R1 final reset");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule